// File: doc/BRIEF.md
# Partitioned Way-Lock Replacement Selector

This block decides which way of one set in an 8-way cache is refilled on a miss. It also keeps the lock bits of that set consistent. Several requesters share the cache. Each requester has its own partition mask, which lists the ways it is allowed to allocate into. A miss from a requester only considers ways that are in its mask and not locked. Among those candidates, a rotating pointer spreads the fills across the ways.

A miss can also ask to lock the line it brings in. The lock is granted only if another usable way would stay unlocked after it. Otherwise the fill still happens, the lock is dropped, and a sticky lock-refusal flag is raised.

A miss can find every usable way locked. This happens when partitioning and locking are mixed badly. In that case the block takes the lowest-numbered usable way, clears its lock and raises a second sticky flag. Each flag has its own interrupt enable and a write-one-to-clear input. The block does not hold the lock state of the set: the current lock bits come in with the request, and the updated bits go out with the chosen way.

Top module: `wlk_repl_sel`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0, victim_way is 0, lock_out is 0 and both flags are 0. The rotating pointer starts at way 0.
- R2: The usable set of a request is the slice part_mask[id*WAYS +: WAYS] of the requesting id. A slice of all zeros, or an id of NUM_REQ or above, means way 0 only. The chosen way is always usable.
- R3: When at least one usable way has a clear lock bit in lock_in, the chosen way is unlocked.
- R4: Among the unlocked usable ways, the chosen way is the first one found from the pointer upward, wrapping past WAYS-1 to 0. After every fill the pointer moves to the chosen way plus one, modulo WAYS.
- R5: When every usable way is locked, the chosen way is the lowest-numbered usable way, and its bit is cleared in lock_out.
- R6: The case in R5 sets starve_flag.
- R7: req_op encodes 0 = idle, 1 = fill, 2 = fill and lock. For a fill and lock with at least two unlocked usable ways, lock_out equals lock_in with the chosen way's bit set.
- R8: For a fill and lock with fewer than two unlocked usable ways, the chosen way's bit is clear in lock_out and lockerr_flag is set. The fill itself still returns a way. This includes the case in R5.
- R9: Both flags are sticky until their clear input is 1 at a clock edge. An event in the same cycle wins over the clear.
- R10: irq_lockerr equals lockerr_flag AND en_lockerr_irq. irq_starve equals starve_flag AND en_starve_irq.
- R11: The results of a fill appear on the clock edge that samples the request, and out_valid is 1 for exactly that cycle. Bits of lock_out outside the usable set equal lock_in. After an idle cycle out_valid is 0 and victim_way and lock_out hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 0 idle, 1 fill, 2 fill and lock |
| req_id | input | IDW | Requesting agent |
| part_mask | input | NUM_REQ*WAYS | Partition masks, WAYS bits per requester |
| lock_in | input | WAYS | Current lock bits of the set |
| clr_lockerr | input | 1 | Write-one-to-clear for lockerr_flag |
| clr_starve | input | 1 | Write-one-to-clear for starve_flag |
| en_lockerr_irq | input | 1 | Interrupt enable for the lock refusal flag |
| en_starve_irq | input | 1 | Interrupt enable for the forced-victim flag |
| out_valid | output | 1 | A fill result is on the outputs |
| victim_way | output | WW | Way chosen for the fill |
| lock_out | output | WAYS | Updated lock bits |
| lockerr_flag | output | 1 | Sticky: a lock request was refused |
| starve_flag | output | 1 | Sticky: no unlocked usable way was found |
| irq_lockerr | output | 1 | Gated lock refusal interrupt |
| irq_starve | output | 1 | Gated forced-victim interrupt |

## Verification
The assertions check on every cycle the rules that hold for any lock pattern:
- the chosen way is usable;
- the chosen way is unlocked whenever a free usable way exists;
- at least one usable way stays unlocked after every fill;
- foreign lock bits pass through unchanged;
- grants, refusals and the forced unlock agree with the count of free usable ways;
- the flags stay set until cleared.

The rotation order of the pointer, the exact choice of the lowest usable way, the handling of all-zero masks, the priority of an event over a clear and the interrupt gating can only be shown by the bench. It sweeps every lock pattern for each requester and both fill kinds, and compares against its own model.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

    typedef enum logic [1:0] {
        WLK_OP_IDLE      = 2'd0,
        WLK_OP_FILL      = 2'd1,
        WLK_OP_FILL_LOCK = 2'd2,
        WLK_OP_RSVD      = 2'd3
    } wlk_op_e;

    typedef enum logic {
        WLK_PICK_FREE   = 1'b0,
        WLK_PICK_FORCED = 1'b1
    } wlk_pick_e;

    // Index of one of the two sticky error flags
    localparam int WLK_FLAG_LOCKERR = 0;
    localparam int WLK_FLAG_STARVE  = 1;
    localparam int WLK_NUM_FLAGS    = 2;

    function automatic bit wlk_is_fill(input wlk_op_e op);
        return (op == WLK_OP_FILL) || (op == WLK_OP_FILL_LOCK);
    endfunction

endpackage

// File: rtl/wlk_usable_sel.sv
module wlk_usable_sel #(
    parameter int WAYS    = 8,
    parameter int NUM_REQ = 4,
    parameter int IDW     = 2
) (
    input  logic [IDW-1:0]          req_id,
    input  logic [NUM_REQ*WAYS-1:0] part_mask,
    output logic [WAYS-1:0]         usable
);
    logic [WAYS-1:0] slice;

    always_comb begin
        slice = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (int'(req_id) == r) slice = part_mask[r*WAYS +: WAYS];
        end
        // an empty partition falls back to the first way only
        usable = (slice == '0) ? WAYS'(1) : slice;
    end
endmodule

// File: rtl/wlk_victim_pick.sv
module wlk_victim_pick
    import wlk_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int WW   = 3
) (
    input  logic [WAYS-1:0] usable,
    input  logic [WAYS-1:0] locks,
    input  logic [WW-1:0]   ptr,
    output logic [WW-1:0]   way,
    output wlk_pick_e       kind,
    output logic            spare
);
    logic [WAYS-1:0] cand;
    logic [WW-1:0]   rr_way;
    logic [WW-1:0]   low_way;
    logic            found;

    assign cand  = usable & ~locks;
    assign spare = ($countones(cand) >= 2);

    // first free usable way at or after the pointer, circularly
    always_comb begin
        rr_way = '0;
        found  = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            int j;
            j = int'(ptr) + i;
            if (j >= WAYS) j = j - WAYS;
            if (!found && cand[j]) begin
                rr_way = WW'(j);
                found  = 1'b1;
            end
        end
    end

    // lowest usable way, used when everything usable is locked
    always_comb begin
        low_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (usable[i]) low_way = WW'(i);
        end
    end

    assign kind = found ? WLK_PICK_FREE : WLK_PICK_FORCED;
    assign way  = found ? rr_way : low_way;
endmodule

// File: rtl/wlk_sticky_flag.sv
module wlk_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_ev)  flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/wlk_repl_sel.sv
module wlk_repl_sel
    import wlk_pkg::*;
#(
    parameter  int WAYS    = 8,
    parameter  int NUM_REQ = 4,
    localparam int WW      = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              req_op,
    input  logic [IDW-1:0]          req_id,
    input  logic [NUM_REQ*WAYS-1:0] part_mask,
    input  logic [WAYS-1:0]         lock_in,
    input  logic                    clr_lockerr,
    input  logic                    clr_starve,
    input  logic                    en_lockerr_irq,
    input  logic                    en_starve_irq,
    output logic                    out_valid,
    output logic [WW-1:0]           victim_way,
    output logic [WAYS-1:0]         lock_out,
    output logic                    lockerr_flag,
    output logic                    starve_flag,
    output logic                    irq_lockerr,
    output logic                    irq_starve
);
    wlk_op_e         op;
    logic            fill;
    logic            want_lock;
    logic [WAYS-1:0] usable;
    logic [WW-1:0]   pick_way;
    wlk_pick_e       pick_kind;
    logic            pick_spare;
    logic [WW-1:0]   ptr_q;
    logic [WW-1:0]   ptr_nxt;
    logic [WAYS-1:0] pick_oh;
    logic [WAYS-1:0] lock_nxt;
    logic            ev_refuse;
    logic            ev_starve;

    logic [WLK_NUM_FLAGS-1:0] fl_set, fl_clr, fl_en, fl_q, fl_irq;

    assign op        = wlk_op_e'(req_op);
    assign fill      = wlk_is_fill(op);
    assign want_lock = (op == WLK_OP_FILL_LOCK);

    wlk_usable_sel #(.WAYS(WAYS), .NUM_REQ(NUM_REQ), .IDW(IDW)) u_use (
        .req_id    (req_id),
        .part_mask (part_mask),
        .usable    (usable)
    );

    wlk_victim_pick #(.WAYS(WAYS), .WW(WW)) u_pick (
        .usable (usable),
        .locks  (lock_in),
        .ptr    (ptr_q),
        .way    (pick_way),
        .kind   (pick_kind),
        .spare  (pick_spare)
    );

    assign pick_oh = WAYS'(1) << pick_way;
    assign ptr_nxt = (pick_way == WW'(WAYS - 1)) ? '0 : pick_way + 1'b1;

    // lock update: forced unlock, granted lock, or refused lock
    always_comb begin
        lock_nxt  = lock_in;
        ev_refuse = 1'b0;
        ev_starve = 1'b0;
        if (pick_kind == WLK_PICK_FORCED) begin
            lock_nxt  = lock_in & ~pick_oh;
            ev_starve = 1'b1;
            ev_refuse = want_lock;
        end else if (want_lock) begin
            if (pick_spare) lock_nxt = lock_in | pick_oh;
            else            ev_refuse = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            victim_way <= '0;
            lock_out   <= '0;
            ptr_q      <= '0;
        end else begin
            out_valid <= fill;
            if (fill) begin
                victim_way <= pick_way;
                lock_out   <= lock_nxt;
                ptr_q      <= ptr_nxt;
            end
        end
    end

    assign fl_set[WLK_FLAG_LOCKERR] = fill && ev_refuse;
    assign fl_set[WLK_FLAG_STARVE]  = fill && ev_starve;
    assign fl_clr[WLK_FLAG_LOCKERR] = clr_lockerr;
    assign fl_clr[WLK_FLAG_STARVE]  = clr_starve;
    assign fl_en[WLK_FLAG_LOCKERR]  = en_lockerr_irq;
    assign fl_en[WLK_FLAG_STARVE]   = en_starve_irq;

    for (genvar g = 0; g < WLK_NUM_FLAGS; g++) begin : g_flag
        wlk_sticky_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_ev  (fl_set[g]),
            .clr_req (fl_clr[g]),
            .irq_en  (fl_en[g]),
            .flag    (fl_q[g]),
            .irq     (fl_irq[g])
        );
    end

    assign lockerr_flag = fl_q[WLK_FLAG_LOCKERR];
    assign starve_flag  = fl_q[WLK_FLAG_STARVE];
    assign irq_lockerr  = fl_irq[WLK_FLAG_LOCKERR];
    assign irq_starve   = fl_irq[WLK_FLAG_STARVE];
endmodule

// File: rtl/wlk_repl_sel_chk.sv
module wlk_repl_sel_chk #(
    parameter int WAYS    = 8,
    parameter int NUM_REQ = 4,
    parameter int WW      = 3,
    parameter int IDW     = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              req_op,
    input logic [IDW-1:0]          req_id,
    input logic [NUM_REQ*WAYS-1:0] part_mask,
    input logic [WAYS-1:0]         lock_in,
    input logic                    clr_lockerr,
    input logic                    clr_starve,
    input logic                    out_valid,
    input logic [WW-1:0]           victim_way,
    input logic [WAYS-1:0]         lock_out,
    input logic                    lockerr_flag,
    input logic                    starve_flag
);
    logic [WAYS-1:0] use_now;
    logic [WAYS-1:0] use_q;
    logic [WAYS-1:0] lk_q;
    logic            lockreq_q;
    logic            rst_q;

    always_comb begin
        use_now = '0;
        for (int r = 0; r < NUM_REQ; r++)
            if (int'(req_id) == r) use_now = part_mask[r*WAYS +: WAYS];
        if (use_now == '0) use_now = WAYS'(1);
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            use_q     <= WAYS'(1);
            lk_q      <= '0;
            lockreq_q <= 1'b0;
        end else begin
            use_q     <= use_now;
            lk_q      <= lock_in;
            lockreq_q <= (req_op == 2'd2);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!out_valid && !lockerr_flag && !starve_flag && lock_out == '0)); // R1
    AST_VICTIM_USABLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> use_q[victim_way]); // R2
    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (use_q & ~lk_q) != '0) |-> !lk_q[victim_way]); // R3
    AST_FORCED_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (use_q & ~lk_q) == '0) |-> (!lock_out[victim_way] && starve_flag)); // R5
    AST_LOCK_GRANT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && lockreq_q && $countones(use_q & ~lk_q) >= 2) |-> lock_out[victim_way]); // R7
    AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && lockreq_q && $countones(use_q & ~lk_q) < 2) |-> (!lock_out[victim_way] && lockerr_flag)); // R8
    AST_ONE_FREE_LEFT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((use_q & ~lock_out) != '0)); // R8
    AST_FOREIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((lock_out & ~use_q) == (lk_q & ~use_q))); // R11
    AST_LOCKERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lockerr_flag && !clr_lockerr) |=> lockerr_flag); // R9
    AST_STARVE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (starve_flag && !clr_starve) |=> starve_flag); // R9
endmodule

bind wlk_repl_sel wlk_repl_sel_chk #(
    .WAYS(WAYS), .NUM_REQ(NUM_REQ), .WW(WW), .IDW(IDW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_op       (req_op),
    .req_id       (req_id),
    .part_mask    (part_mask),
    .lock_in      (lock_in),
    .clr_lockerr  (clr_lockerr),
    .clr_starve   (clr_starve),
    .out_valid    (out_valid),
    .victim_way   (victim_way),
    .lock_out     (lock_out),
    .lockerr_flag (lockerr_flag),
    .starve_flag  (starve_flag)
);

// File: tb/wlk_repl_sel_bench.sv
module wlk_repl_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS    = 8;
    localparam int NUM_REQ = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_id = 2'd0;
    logic [31:0] part_mask = '0;
    logic [7:0]  lock_in = '0;
    logic        clr_lockerr = 1'b0;
    logic        clr_starve = 1'b0;
    logic        en_lockerr_irq = 1'b0;
    logic        en_starve_irq = 1'b0;
    logic        out_valid;
    logic [2:0]  victim_way;
    logic [7:0]  lock_out;
    logic        lockerr_flag;
    logic        starve_flag;
    logic        irq_lockerr;
    logic        irq_starve;

    int checks = 0;
    int fails  = 0;
    int ptr_m  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wlk_repl_sel #(.WAYS(WAYS), .NUM_REQ(NUM_REQ)) u_wlk_repl_sel (
        .clk(clk), .rst(rst), .req_op(req_op), .req_id(req_id),
        .part_mask(part_mask), .lock_in(lock_in),
        .clr_lockerr(clr_lockerr), .clr_starve(clr_starve),
        .en_lockerr_irq(en_lockerr_irq), .en_starve_irq(en_starve_irq),
        .out_valid(out_valid), .victim_way(victim_way), .lock_out(lock_out),
        .lockerr_flag(lockerr_flag), .starve_flag(starve_flag),
        .irq_lockerr(irq_lockerr), .irq_starve(irq_starve)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input int op, input int id, input logic [7:0] li);
        logic [7:0] use_m, cand, exp_lock, bit_oh;
        int  v, held_v;
        bit  forced, exp_lerr, exp_starve, found;
        @(negedge clk);
        req_op = 2'(op); req_id = 2'(id); lock_in = li;
        en_lockerr_irq = li[0]; en_starve_irq = li[3];
        use_m = part_mask[id*8 +: 8];
        if (use_m == 8'h00) use_m = 8'h01;
        cand = use_m & ~li;
        forced = (cand == 8'h00);
        v = 0; found = 1'b0;
        if (!forced) begin
            for (int i = 0; i < 8; i++) begin
                int j;
                j = (ptr_m + i) % 8;
                if (!found && cand[j]) begin v = j; found = 1'b1; end
            end
        end else begin
            for (int i = 7; i >= 0; i--) if (use_m[i]) v = i;
        end
        bit_oh = 8'(1) << v;
        exp_lerr = 1'b0; exp_starve = 1'b0; exp_lock = li;
        if (forced) begin
            exp_lock = li & ~bit_oh; exp_starve = 1'b1; exp_lerr = (op == 2);
        end else if (op == 2) begin
            if ($countones(cand) >= 2) exp_lock = li | bit_oh;
            else exp_lerr = 1'b1;
        end
        @(negedge clk);
        req_op = 2'd0;
        ptr_m = (v + 1) % 8;
        chk(out_valid == 1'b1, "R11 out_valid", int'(out_valid), 1);
        chk(use_m[victim_way] == 1'b1, "R2 victim usable", int'(victim_way), v);
        chk(int'(victim_way) == v, forced ? "R5 forced victim" : "R4 rr victim", int'(victim_way), v);
        chk(lock_out == exp_lock, forced ? "R5 lock_out" : ((op == 2) ? "R7/R8 lock_out" : "R3 lock_out"),
            int'(lock_out), int'(exp_lock));
        chk(lockerr_flag == exp_lerr, "R8 lockerr_flag", int'(lockerr_flag), int'(exp_lerr));
        chk(starve_flag == exp_starve, "R6 starve_flag", int'(starve_flag), int'(exp_starve));
        chk(irq_lockerr == (exp_lerr & li[0]), "R10 irq_lockerr", int'(irq_lockerr), int'(exp_lerr & li[0]));
        chk(irq_starve == (exp_starve & li[3]), "R10 irq_starve", int'(irq_starve), int'(exp_starve & li[3]));
        held_v = int'(victim_way);
        clr_lockerr = 1'b1; clr_starve = 1'b1;
        @(negedge clk);
        clr_lockerr = 1'b0; clr_starve = 1'b0;
        chk(!out_valid && int'(victim_way) == held_v && lock_out == exp_lock,
            "R11 idle hold", int'({out_valid, lock_out}), int'({1'b0, exp_lock}));
        chk(!lockerr_flag && !starve_flag, "R9 cleared", int'({lockerr_flag, starve_flag}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && lock_out == 8'h00 && victim_way == 3'd0, "R1 outputs in reset",
            int'({out_valid, lock_out}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !lockerr_flag && !starve_flag && lock_out == 8'h00,
            "R1 after reset", int'({out_valid, lockerr_flag, starve_flag, lock_out}), 0);

        // R1 pointer starts at way 0: full mask, nothing locked
        part_mask = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        do_req(1, 0, 8'h00);

        // sweeps over all lock patterns, both fill kinds, all requesters
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 0) part_mask = {8'hFF, 8'h00, 8'hF0, 8'h03};
            else           part_mask = {8'h7E, 8'h01, 8'h24, 8'h81};
            for (int id = 0; id < NUM_REQ; id++)
                for (int op = 1; op <= 2; op++)
                    for (int li = 0; li < 256; li++)
                        do_req(op, id, 8'(li));
        end

        // R9: event in the same cycle as a clear wins; flag then sticks
        part_mask = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        @(negedge clk);
        req_op = 2'd2; req_id = 2'd3; lock_in = 8'hFE; clr_lockerr = 1'b1;
        @(negedge clk);
        req_op = 2'd0; clr_lockerr = 1'b0;
        chk(lockerr_flag == 1'b1, "R9 set beats clear", int'(lockerr_flag), 1);
        repeat (2) @(negedge clk);
        chk(lockerr_flag == 1'b1, "R9 sticky", int'(lockerr_flag), 1);
        clr_lockerr = 1'b1;
        @(negedge clk);
        clr_lockerr = 1'b0;
        chk(lockerr_flag == 1'b0, "R9 w1c", int'(lockerr_flag), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule